// File: doc/BRIEF.md
# Dual-Slot Card Status Change Unit

This block watches the status pins of two removable-card slots and turns their activity into an interrupt request for a host processor. Each slot supplies eight pins: two voltage-sense pins, write protect, two card-detect pins, two battery/status pins and ready. Every pin passes through a two-flop synchroniser. The synchronised values can be read back through a pin-view register. Transitions on the relevant pins are latched as events in a change register. Each event can be routed to a registered interrupt output through an enable register.

Both slots share the pin-view, change and enable registers. Slot A occupies the upper half-word and slot B uses the same layout in the lower half-word. Each slot also owns a control register with a card-reset output, an active-low buffer output-enable output, and two stored interrupt-level mask bytes.

The host reaches the registers through a plain single-cycle bus. Writes are captured on the clock edge that follows `bus_wr`. Read data follows `bus_addr` combinationally. Register addresses are: 0 pin view (read only), 1 change, 2 enable, 3 slot A control, 4 slot B control. Any other address reads zero and ignores writes.

Top module: `card_status_unit`

## Requirements
- R1: After reset the registers hold these values: change latches 0, enable 0, both control registers 0x00000080, irq 0, card_reset 2'b00, buf_oe_n 2'b11. With all pins low, the change register reads 0x00800080, because only the ready-low level bits are set.
- R2: Pin-view layout for slot A, with pin vector bit 7..0 mapped to register bits 31..24: VS1 31, VS2 30, write protect 29, CD2 28, CD1 27, BVD2 26, BVD1 25, ready 24. Bits 23:16 read zero. A pin change shows in the pin view two clocks after it is applied.
- R3: A change of the synchronised write-protect, BVD2 or BVD1 value sets the change bit at the same position as that pin. The bit is set on the third clock after the pin moves. Voltage-sense pins never set change bits.
- R4: Writing the change register clears every latched bit where the written data has a one. Bits written with zero keep their value.
- R5: Ready events for slot A are: bit 23 while ready is low, bit 22 while ready is high, bit 21 latched on a rising edge, bit 20 latched on a falling edge. Bits 23 and 22 follow the pin and are not affected by a clearing write.
- R6: The enable register reads back what was written. irq goes high on the clock after an enabled change bit is set, and never earlier.
- R7: irq goes low on the clock after the last enabled change bit clears.
- R8: A card-detect change is latched only when, after the change, CD1 and CD2 agree. In that case the bit is set for each detect pin that moved. A transition that leaves the two pins different is not reported.
- R9: When a pin event and a clearing write hit the same change bit in the same cycle, the bit stays set.
- R10: In each control register, bit 6 drives card_reset (active high) and bit 7 drives buf_oe_n (active low). Bits 31:16 are stored. All other bits read zero. The outputs follow on the clock after the write.
- R11: Slot B uses the slot A layout shifted right by 16 in the pin-view, change and enable registers. The events of slot B are independent of those of slot A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_a_pins | input | 8 | Slot A pins {VS1, VS2, WP, CD2, CD1, BVD2, BVD1, RDY} |
| slot_b_pins | input | 8 | Slot B pins, same order |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Registered status change interrupt |
| card_reset | output | 2 | Card reset per slot, bit 0 is slot A |
| buf_oe_n | output | 2 | Active-low buffer enable per slot, bit 0 is slot A |

## Verification
The assertions check the following on every cycle:
- every latched pin event matches a real change of the synchronised pin;
- detect events only occur when CD1 and CD2 agree;
- the two ready level bits are always mutually exclusive;
- irq tracks the enabled change bits with one register of delay;
- clearing writes and simultaneous sets resolve correctly;
- control writes reach the outputs.

Some behaviour can only be shown by the bench scenarios. These are the exact clock count from a pin move to the change bit and to irq, and suppression of detect events during the staggered insertion sequence. They also cover the slot B half-word shift and the read-back of stored and reserved control bits.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int SLOTS   = 2;
  localparam int REG_W   = 32;
  localparam int FIELD_W = REG_W / SLOTS;
  localparam int PIN_W   = 8;
  localparam int ADDR_W  = 3;

  // register addresses
  localparam int ADDR_PIN  = 0;
  localparam int ADDR_CHG  = 1;
  localparam int ADDR_EN   = 2;
  localparam int ADDR_CTL0 = 3;

  // pin vector indices
  localparam int I_VS1  = 7;
  localparam int I_VS2  = 6;
  localparam int I_WP   = 5;
  localparam int I_CD2  = 4;
  localparam int I_CD1  = 3;
  localparam int I_BVD2 = 2;
  localparam int I_BVD1 = 1;
  localparam int I_RDY  = 0;

  // positions within one slot field
  localparam int F_PIN0  = FIELD_W - PIN_W;
  localparam int F_RLO   = 7;
  localparam int F_RHI   = 6;
  localparam int F_RRISE = 5;
  localparam int F_RFALL = 4;

  localparam logic [FIELD_W-1:0] LATCH_F = 16'h3E30;
  localparam logic [FIELD_W-1:0] LEVEL_F = 16'h00C0;

  // control register
  localparam int C_RST = 6;
  localparam int C_OEN = 7;
  localparam logic [REG_W-1:0] CTL_KEEP = 32'hFFFF_00C0;
  localparam logic [REG_W-1:0] CTL_INIT = 32'h0000_0080;
endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end
  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cs_slot_events.sv
module cs_slot_events
  import cs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_W-1:0]   pins_s,
  output logic [FIELD_W-1:0] set_f,
  output logic [FIELD_W-1:0] level_f
);
  logic [PIN_W-1:0] prev_q, prev_d, diff;
  logic             cd_agree;

  always_comb begin
    prev_d   = pins_s;
    diff     = pins_s ^ prev_q;
    cd_agree = (pins_s[I_CD1] == pins_s[I_CD2]);
    set_f    = '0;
    level_f  = '0;
    set_f[F_PIN0 + I_WP]   = diff[I_WP];
    set_f[F_PIN0 + I_BVD2] = diff[I_BVD2];
    set_f[F_PIN0 + I_BVD1] = diff[I_BVD1];
    set_f[F_PIN0 + I_CD2]  = diff[I_CD2] & cd_agree;
    set_f[F_PIN0 + I_CD1]  = diff[I_CD1] & cd_agree;
    set_f[F_RRISE]         = diff[I_RDY] &  pins_s[I_RDY];
    set_f[F_RFALL]         = diff[I_RDY] & ~pins_s[I_RDY];
    level_f[F_RLO]         = ~pins_s[I_RDY];
    level_f[F_RHI]         =  pins_s[I_RDY];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/card_status_unit.sv
module card_status_unit
  import cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  slot_a_pins,
  input  logic [PIN_W-1:0]  slot_b_pins,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  output logic [SLOTS-1:0]  card_reset,
  output logic [SLOTS-1:0]  buf_oe_n
);
  localparam logic [REG_W-1:0] LATCH_ALL = {SLOTS{LATCH_F}};

  logic             rst_n_sync;
  logic [PIN_W-1:0] pins_raw [SLOTS];
  logic [REG_W-1:0] pin_view, set_vec, level_vec, chg_view;
  logic [REG_W-1:0] chg_q, chg_d, en_q, en_d, clr_mask;
  logic [REG_W-1:0] ctl_q [SLOTS];
  logic [REG_W-1:0] ctl_d [SLOTS];
  logic             irq_q, irq_d;

  cs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  assign pins_raw[0] = slot_a_pins;
  assign pins_raw[1] = slot_b_pins;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int TOP = REG_W - 1 - FIELD_W * s;
    logic [PIN_W-1:0]   pins_s;
    logic [FIELD_W-1:0] set_f, level_f;

    cs_sync #(.W(PIN_W), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n_sync), .d(pins_raw[s]), .q(pins_s));

    cs_slot_events u_ev (
      .clk(clk), .rst_n(rst_n_sync), .pins_s(pins_s),
      .set_f(set_f), .level_f(level_f));

    assign pin_view[TOP -: FIELD_W]  = {pins_s, {(FIELD_W-PIN_W){1'b0}}};
    assign set_vec[TOP -: FIELD_W]   = set_f;
    assign level_vec[TOP -: FIELD_W] = level_f;
    assign card_reset[s]             = ctl_q[s][C_RST];
    assign buf_oe_n[s]               = ctl_q[s][C_OEN];
  end

  assign chg_view = chg_q | level_vec;

  // next state
  always_comb begin
    clr_mask = (bus_wr && bus_addr == ADDR_W'(ADDR_CHG)) ? bus_wdata : '0;
    chg_d    = ((chg_q & ~clr_mask) | set_vec) & LATCH_ALL;
    en_d     = (bus_wr && bus_addr == ADDR_W'(ADDR_EN)) ? bus_wdata : en_q;
    for (int s = 0; s < SLOTS; s++) begin
      ctl_d[s] = (bus_wr && bus_addr == ADDR_W'(ADDR_CTL0 + s))
               ? (bus_wdata & CTL_KEEP) : ctl_q[s];
    end
    irq_d = |(chg_view & en_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      chg_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
      for (int s = 0; s < SLOTS; s++) ctl_q[s] <= CTL_INIT;
    end else begin
      chg_q <= chg_d;
      en_q  <= en_d;
      irq_q <= irq_d;
      for (int s = 0; s < SLOTS; s++) ctl_q[s] <= ctl_d[s];
    end
  end

  assign irq = irq_q;

  // read path
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(ADDR_PIN):  bus_rdata = pin_view;
      ADDR_W'(ADDR_CHG):  bus_rdata = chg_view;
      ADDR_W'(ADDR_EN):   bus_rdata = en_q;
      default: begin
        for (int s = 0; s < SLOTS; s++)
          if (bus_addr == ADDR_W'(ADDR_CTL0 + s)) bus_rdata = ctl_q[s];
      end
    endcase
  end
endmodule

// File: rtl/cs_checker.sv
module cs_checker
  import cs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  pin_view,
  input logic [REG_W-1:0]  set_vec,
  input logic [REG_W-1:0]  chg_q,
  input logic [REG_W-1:0]  chg_view,
  input logic [REG_W-1:0]  en_q,
  input logic              irq,
  input logic [SLOTS-1:0]  card_reset,
  input logic [SLOTS-1:0]  buf_oe_n
);
  localparam logic [REG_W-1:0] PIN_EV = 32'h3E00_3E00;

  AST_EDGE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & PIN_EV) & ~(pin_view ^ $past(pin_view))) == '0); // R3

  AST_CD_AGREE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[28] || set_vec[27]) |-> (pin_view[28] == pin_view[27])); // R8

  AST_CD_AGREE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[12] || set_vec[11]) |-> (pin_view[12] == pin_view[11])); // R11

  AST_LEVEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(chg_view[23:22]) == 1) && ($countones(chg_view[7:6]) == 1)); // R5

  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(chg_view & en_q))); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(ADDR_CHG))
    |=> ((chg_q & $past(bus_wdata & ~set_vec)) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((chg_q & $past(set_vec)) == $past(set_vec))); // R9

  AST_CTL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(ADDR_CTL0))
    |=> (card_reset[0] == $past(bus_wdata[C_RST]) &&
         buf_oe_n[0] == $past(bus_wdata[C_OEN]))); // R10
endmodule

bind card_status_unit cs_checker u_chk (
  .clk(clk), .rst_n(rst_n_sync), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_view(pin_view), .set_vec(set_vec),
  .chg_q(chg_q), .chg_view(chg_view), .en_q(en_q), .irq(irq),
  .card_reset(card_reset), .buf_oe_n(buf_oe_n));

// File: tb/sim_card_status_unit.sv
`timescale 1ns/10ps
module sim_card_status_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  slot_a_pins, slot_b_pins;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [1:0]  card_reset, buf_oe_n;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 card_reset, 3 buf_oe_n
    logic [31:0] exp;
    int          req;
    string       what;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;

  always #2.5 clk = ~clk;

  card_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .slot_a_pins(slot_a_pins),
    .slot_b_pins(slot_b_pins), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .card_reset(card_reset), .buf_oe_n(buf_oe_n));

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = {31'd0, irq};
          2: act = {30'd0, card_reset};
          default: act = {30'd0, buf_oe_n};
        endcase
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL R%0d %s: got %h expected %h", it.req, it.what, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int kind, input logic [2:0] a, input logic [31:0] e,
                      input int req, input string what);
    item_t it;
    if (kind == 0) bus_addr = a;
    #0.1;
    it.kind = kind; it.exp = e; it.req = req; it.what = what;
    q.push_back(it);
    -> chk_ev;
    #0.1;
  endtask

  task automatic exp_reg(input logic [2:0] a, input logic [31:0] e, input int req,
                         input string what);
    push(0, a, e, req, what);
  endtask

  task automatic exp_irq(input logic e, input int req, input string what);
    push(1, 3'd0, {31'd0, e}, req, what);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  localparam logic [2:0] PIN = 3'd0, CHG = 3'd1, EN = 3'd2, CTA = 3'd3, CTB = 3'd4;

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; slot_a_pins = 8'h00; slot_b_pins = 8'h00;
    bus_addr = 3'd0; bus_wr = 1'b0; bus_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    exp_reg(CHG, 32'h0080_0080, 1, "reset change");
    exp_reg(EN,  32'h0000_0000, 1, "reset enable");
    exp_reg(CTA, 32'h0000_0080, 1, "reset ctl A");
    exp_reg(CTB, 32'h0000_0080, 1, "reset ctl B");
    exp_irq(1'b0, 1, "reset irq");
    push(2, 3'd0, 32'h0, 1, "reset card_reset");
    push(3, 3'd0, 32'h3, 1, "reset buf_oe_n");
    tick(1);

    // R2 pin layout, R3 write-protect edge on slot B, R11 shift
    slot_a_pins = 8'hC0; slot_b_pins = 8'h20;
    tick(2);
    exp_reg(PIN, 32'hC000_2000, 2, "pin view two clocks later");
    exp_reg(CHG, 32'h0080_0080, 3, "no event yet after two clocks");
    tick(1);
    exp_reg(CHG, 32'h0080_2080, 3, "WP event on slot B (R11)");
    exp_irq(1'b0, 6, "disabled event gives no irq");
    tick(1);

    // R6 enable and irq timing
    wr(EN, 32'h0000_2000);
    exp_irq(1'b0, 6, "irq not yet one clock after enable");
    exp_reg(EN, 32'h0000_2000, 6, "enable readback");
    tick(1);
    exp_irq(1'b1, 6, "irq asserted");

    // R4 clearing, R7 deassert timing
    wr(CHG, 32'h0000_0000);
    exp_reg(CHG, 32'h0080_2080, 4, "zero write keeps bits");
    wr(CHG, 32'h0000_2000);
    exp_reg(CHG, 32'h0080_0080, 4, "one write clears");
    exp_irq(1'b1, 7, "irq still high same clock");
    tick(1);
    exp_irq(1'b0, 7, "irq low next clock");
    wr(CHG, 32'h0080_0080);
    exp_reg(CHG, 32'h0080_0080, 5, "level bits ignore clear");

    // R5 ready levels and edges
    wr(EN, 32'h0080_0000);
    tick(1);
    exp_irq(1'b1, 5, "ready-low level raises irq");
    slot_a_pins = 8'hC1;
    tick(3);
    exp_reg(CHG, 32'h0060_0080, 5, "ready high level and rising edge");
    exp_irq(1'b0, 5, "irq drops with level");
    wr(EN, 32'h0);
    wr(CHG, 32'h0020_0000);
    exp_reg(CHG, 32'h0040_0080, 5, "rising edge cleared");
    slot_a_pins = 8'hC0;
    tick(3);
    exp_reg(CHG, 32'h0090_0080, 5, "falling edge latched");
    wr(CHG, 32'h0010_0000);

    // R8 card detect agreement
    slot_a_pins = 8'hC8;
    tick(4);
    exp_reg(CHG, 32'h0080_0080, 8, "disagreeing detect suppressed");
    exp_reg(PIN, 32'hC800_2000, 2, "CD1 in pin view");
    slot_a_pins = 8'hD8;
    tick(4);
    exp_reg(CHG, 32'h1080_0080, 8, "agreeing detect latched");
    wr(CHG, 32'h1000_0000);
    slot_a_pins = 8'hC0;
    tick(4);
    exp_reg(CHG, 32'h1880_0080, 8, "both detect pins at once");
    wr(CHG, 32'h1800_0000);

    // R3 battery pins on slot B
    slot_b_pins = 8'h26;
    tick(4);
    exp_reg(CHG, 32'h0080_0680, 3, "BVD edges slot B");
    wr(CHG, 32'h0000_0600);
    exp_reg(CHG, 32'h0080_0080, 4, "BVD cleared");

    // R9 set beats clear in the same clock
    slot_b_pins = 8'h06;
    tick(2);
    wr(CHG, 32'h0000_2000);
    exp_reg(CHG, 32'h0080_2080, 9, "set wins over clear");
    wr(CHG, 32'h0000_2000);
    exp_reg(CHG, 32'h0080_0080, 9, "later clear works");

    // R10 control registers
    wr(CTA, 32'hAB00_00C0);
    exp_reg(CTA, 32'hAB00_00C0, 10, "ctl A readback");
    push(2, 3'd0, 32'h1, 10, "card_reset after ctl A");
    push(3, 3'd0, 32'h3, 10, "buf_oe_n after ctl A");
    tick(1);
    wr(CTB, 32'hFFFF_FFFF);
    exp_reg(CTB, 32'hFFFF_00C0, 10, "ctl B reserved bits zero");
    push(2, 3'd0, 32'h3, 10, "card_reset both");
    tick(1);
    wr(CTA, 32'h0000_0040);
    exp_reg(CTA, 32'h0000_0040, 10, "ctl A rewrite");
    push(3, 3'd0, 32'h2, 10, "buf_oe_n slot A enabled");
    exp_reg(3'd7, 32'h0, 10, "unmapped address");
    tick(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule